// File: doc/BRIEF.md
# Sparse Gate Index Compactor

The block converts a two-part clock identifier into a dense slot number for a table of clock handles. A requester presents a primary selector and a secondary index with a valid strobe. One clock later the block returns a response strobe together with either a slot number or an invalid flag.

A primary equal to one selects a small group of six fixed clocks. The secondary index of this group is passed through unchanged as the slot number. Any other primary selects the gate path. On the gate path the secondary index names one bit of a sparse map, held as a parameter of three 64-bit words. The slot number is the rank of that bit among the set bits of the map, placed after the fixed group. For a gate, the secondary index is eight times the byte distance of its enable register from the first enable register, plus its bit position.

The rank comes from per-word population counts of a masked map. The word counts are summed and then registered.

Top module: `gate_rank_lookup`

## Requirements
- R1: While reset is active, and after it is released with no request, `rsp_valid`, `rsp_invalid` and `rsp_index` are all 0.
- R2: A response (`rsp_valid`=1) appears on the clock edge after each cycle in which `req_valid` is 1. It appears after no other cycle.
- R3: When the primary is 1 and the secondary is below 6, the response has `rsp_invalid`=0 and `rsp_index` equal to the secondary.
- R4: When the primary is 1 and the secondary is 6 or more, the response is invalid.
- R5: When the primary is not 1 and the secondary is 192 or more, the response is invalid.
- R6: When the primary is not 1 and map bit number `secondary` is 0, the response is invalid. That bit lies in word secondary/64, at bit secondary%64 of the word.
- R7: When the primary is not 1 and the map bit is set, `rsp_index` equals 5 plus the number of set map bits at positions 0 through the secondary, inclusive.
- R8: An invalid response carries `rsp_index`=0 and `rsp_invalid`=1. The flag lasts for that response only and does not affect a request in the next cycle.
- R9: Every primary value other than 1, including 0, 2 and 255, takes the gate path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_primary | input | 8 | Primary selector |
| req_secondary | input | 8 | Secondary index |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_index | output | 8 | Dense slot number, 0 when invalid |
| rsp_invalid | output | 1 | Request could not be resolved |

## Verification
A response for one request and the capture of the next request happen on the same clock edge. An invalid answer must therefore not leak into the valid answer that follows it. The bench issues an out-of-map request and a resolvable gate request in consecutive cycles, and the reverse order as well. It then checks that each response carries only its own flag and slot number. The fixed-group boundary (secondary 5 against 6) and the gate-range edge (191 against 192) are also judged in back-to-back order.

// File: rtl/gri_pkg.sv
package gri_pkg;
  localparam int ID_W  = 8;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             valid;
    logic             invalid;
    logic [IDX_W-1:0] index;
  } gri_rsp_t;
endpackage

// File: rtl/gri_rst_sync.sv
module gri_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gri_word_rank.sv
module gri_word_rank #(
  parameter int WORD_W   = 64,
  parameter int WORD_IDX = 0,
  parameter int SEL_W    = 2,
  parameter int BIT_W    = 6,
  localparam int CNT_W   = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] word_bits,
  input  logic [SEL_W-1:0]  sel_word,
  input  logic [BIT_W-1:0]  sel_bit,
  output logic [CNT_W-1:0]  count
);
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] kept;

  // Full word below the selected one, prefix mask on it, nothing above.
  always_comb begin
    for (int b = 0; b < WORD_W; b++) begin
      if (int'(sel_word) > WORD_IDX)       mask[b] = 1'b1;
      else if (int'(sel_word) == WORD_IDX) mask[b] = (b <= int'(sel_bit));
      else                                 mask[b] = 1'b0;
    end
  end

  assign kept = word_bits & mask;

  always_comb begin
    count = '0;
    for (int b = 0; b < WORD_W; b++) count = count + CNT_W'(kept[b]);
  end
endmodule

// File: rtl/gri_rank_sum.sv
module gri_rank_sum #(
  parameter int MAP_WORDS = 3,
  parameter int WORD_W    = 64,
  parameter int ID_W      = 8,
  parameter logic [MAP_WORDS*WORD_W-1:0] MAP = '0,
  localparam int MAP_BITS = MAP_WORDS * WORD_W,
  localparam int RANK_W   = $clog2(MAP_BITS + 1),
  localparam int PAD_BITS = (MAP_BITS > (1 << ID_W)) ? MAP_BITS : (1 << ID_W)
) (
  input  logic [ID_W-1:0]   sec,
  output logic [RANK_W-1:0] rank,
  output logic              in_range,
  output logic              hit
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int SEL_W = (ID_W > BIT_W) ? ID_W - BIT_W : 1;
  localparam logic [PAD_BITS-1:0] MAP_PAD = PAD_BITS'(MAP);

  logic [SEL_W-1:0] sel_word;
  logic [BIT_W-1:0] sel_bit;
  logic [CNT_W-1:0] word_cnt [MAP_WORDS];

  assign sel_word = SEL_W'(sec >> BIT_W);
  assign sel_bit  = sec[BIT_W-1:0];
  assign in_range = (32'(sec) < MAP_BITS);
  assign hit      = in_range & MAP_PAD[sec];

  for (genvar w = 0; w < MAP_WORDS; w++) begin : g_word
    gri_word_rank #(
      .WORD_W  (WORD_W),
      .WORD_IDX(w),
      .SEL_W   (SEL_W),
      .BIT_W   (BIT_W)
    ) u_rank (
      .word_bits(MAP[w*WORD_W +: WORD_W]),
      .sel_word (sel_word),
      .sel_bit  (sel_bit),
      .count    (word_cnt[w])
    );
  end

  always_comb begin
    rank = '0;
    for (int w = 0; w < MAP_WORDS; w++) rank = rank + RANK_W'(word_cnt[w]);
  end
endmodule

// File: rtl/gate_rank_lookup.sv
module gate_rank_lookup #(
  parameter int MAP_WORDS     = 3,
  parameter int WORD_W        = 64,
  parameter int FIXED_COUNT   = 6,
  parameter int FIXED_PRIMARY = 1,
  parameter logic [MAP_WORDS*WORD_W-1:0] MAP =
    {64'h04777f33f6fec9ff, 64'h0000000000000001, 64'h000000f17ef417ff}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [gri_pkg::ID_W-1:0]  req_primary,
  input  logic [gri_pkg::ID_W-1:0]  req_secondary,
  output logic                    rsp_valid,
  output logic [gri_pkg::IDX_W-1:0] rsp_index,
  output logic                    rsp_invalid
);
  import gri_pkg::*;

  localparam int MAP_BITS = MAP_WORDS * WORD_W;
  localparam int RANK_W   = $clog2(MAP_BITS + 1);

  logic              rst_sync_n;
  logic [RANK_W-1:0] rank;
  logic              in_range;
  logic              hit;
  gri_rsp_t          rsp_d, rsp_q;
  logic              rsp_en;

  gri_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  gri_rank_sum #(
    .MAP_WORDS(MAP_WORDS),
    .WORD_W   (WORD_W),
    .ID_W     (ID_W),
    .MAP      (MAP)
  ) u_sum (
    .sec     (req_secondary),
    .rank    (rank),
    .in_range(in_range),
    .hit     (hit)
  );

  // Next-state decode of one request.
  always_comb begin
    rsp_d = '0;
    if (req_valid) begin
      rsp_d.valid = 1'b1;
      if (32'(req_primary) == FIXED_PRIMARY) begin
        if (32'(req_secondary) < FIXED_COUNT) rsp_d.index   = IDX_W'(req_secondary);
        else                                  rsp_d.invalid = 1'b1;
      end else if (in_range && hit) begin
        rsp_d.index = IDX_W'(FIXED_COUNT - 1) + IDX_W'(rank);
      end else begin
        rsp_d.invalid = 1'b1;
      end
    end
  end

  // Load on a new request, or to clear the previous response.
  assign rsp_en = req_valid | rsp_q.valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rsp_q <= '0;
    else if (rsp_en)  rsp_q <= rsp_d;
  end

  assign rsp_valid   = rsp_q.valid;
  assign rsp_index   = rsp_q.index;
  assign rsp_invalid = rsp_q.invalid;
endmodule

// File: rtl/gate_rank_lookup_chk.sv
module gate_rank_lookup_chk #(
  parameter int FIXED_COUNT   = 6,
  parameter int FIXED_PRIMARY = 1,
  parameter int MAP_BITS      = 192
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [7:0] req_primary,
  input logic [7:0] req_secondary,
  input logic       rsp_valid,
  input logic [7:0] rsp_index,
  input logic       rsp_invalid
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3
  fixed_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && 32'(req_primary) == FIXED_PRIMARY && 32'(req_secondary) < FIXED_COUNT)
      |=> (!rsp_invalid && rsp_index == $past(req_secondary)));

  // R4
  fixed_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && 32'(req_primary) == FIXED_PRIMARY && 32'(req_secondary) >= FIXED_COUNT)
      |=> rsp_invalid);

  // R5
  range_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && 32'(req_primary) != FIXED_PRIMARY && 32'(req_secondary) >= MAP_BITS)
      |=> rsp_invalid);

  // R7
  gate_above_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && 32'(req_primary) != FIXED_PRIMARY)
      |=> (rsp_invalid || 32'(rsp_index) >= FIXED_COUNT));

  // R8
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_invalid |-> (rsp_valid && rsp_index == 8'd0));
endmodule

bind gate_rank_lookup gate_rank_lookup_chk #(
  .FIXED_COUNT  (FIXED_COUNT),
  .FIXED_PRIMARY(FIXED_PRIMARY),
  .MAP_BITS     (MAP_WORDS * WORD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .req_valid    (req_valid),
  .req_primary  (req_primary),
  .req_secondary(req_secondary),
  .rsp_valid    (rsp_valid),
  .rsp_index    (rsp_index),
  .rsp_invalid  (rsp_invalid)
);

// File: tb/sim_gate_rank_lookup.sv
`timescale 1ns/1ps
module sim_gate_rank_lookup;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [7:0] req_primary;
  logic [7:0] req_secondary;
  logic       rsp_valid;
  logic [7:0] rsp_index;
  logic       rsp_invalid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gate_rank_lookup u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_primary(req_primary), .req_secondary(req_secondary),
    .rsp_valid(rsp_valid), .rsp_index(rsp_index), .rsp_invalid(rsp_invalid)
  );

  // {tag, primary, secondary, expected invalid, expected index}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {8'd3, 8'd1,   8'd0,   1'b0, 8'd0 },
    {8'd3, 8'd1,   8'd5,   1'b0, 8'd5 },
    {8'd4, 8'd1,   8'd6,   1'b1, 8'd0 },
    {8'd4, 8'd1,   8'd255, 1'b1, 8'd0 },
    {8'd7, 8'd0,   8'd0,   1'b0, 8'd6 },
    {8'd9, 8'd2,   8'd12,  1'b0, 8'd17},
    {8'd6, 8'd0,   8'd11,  1'b1, 8'd0 },
    {8'd7, 8'd0,   8'd39,  1'b0, 8'd33},
    {8'd7, 8'd0,   8'd64,  1'b0, 8'd34},
    {8'd6, 8'd0,   8'd65,  1'b1, 8'd0 },
    {8'd9, 8'd255, 8'd128, 1'b0, 8'd35},
    {8'd7, 8'd0,   8'd130, 1'b0, 8'd37},
    {8'd7, 8'd0,   8'd186, 1'b0, 8'd77},
    {8'd6, 8'd0,   8'd191, 1'b1, 8'd0 },
    {8'd5, 8'd0,   8'd192, 1'b1, 8'd0 },
    {8'd5, 8'd3,   8'd255, 1'b1, 8'd0 }
  };

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_rsp(input string tag, input logic ev, input logic ei,
                           input logic [7:0] ex);
    checks++;
    if (rsp_valid !== ev || rsp_invalid !== ei || rsp_index !== ex) begin
      errors++;
      $display("FAIL %s: got valid=%0b invalid=%0b index=%0d, expected valid=%0b invalid=%0b index=%0d",
               tag, rsp_valid, rsp_invalid, rsp_index, ev, ei, ex);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] p, input logic [7:0] s);
    req_valid = v; req_primary = p; req_secondary = s;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(1'b0, 8'd0, 8'd0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_rsp("R1", 1'b0, 1'b0, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_rsp("R1", 1'b0, 1'b0, 8'd0);

    // Vector table, one request per cycle, each checked one edge later.
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][24:17], VEC[i][16:9]);
      @(negedge clk);
      check_rsp(tag_name(int'(VEC[i][32:25])), 1'b1, VEC[i][8], VEC[i][7:0]);
    end
    drive(1'b0, 8'd0, 8'd0);
    @(negedge clk);
    // R2: an idle cycle yields no response
    check_rsp("R2", 1'b0, 1'b0, 8'd0);

    // R8: invalid then valid back to back, then valid then invalid
    drive(1'b1, 8'd0, 8'd192);
    @(negedge clk);
    check_rsp("R8", 1'b1, 1'b1, 8'd0);
    drive(1'b1, 8'd0, 8'd12);
    @(negedge clk);
    check_rsp("R8", 1'b1, 1'b0, 8'd17);
    drive(1'b1, 8'd1, 8'd6);
    @(negedge clk);
    check_rsp("R8", 1'b1, 1'b1, 8'd0);
    drive(1'b1, 8'd1, 8'd5);
    @(negedge clk);
    check_rsp("R8", 1'b1, 1'b0, 8'd5);
    drive(1'b1, 8'd0, 8'd191);
    @(negedge clk);
    check_rsp("R6", 1'b1, 1'b1, 8'd0);
    drive(1'b0, 8'd0, 8'd0);
    @(negedge clk);
    check_rsp("R2", 1'b0, 1'b0, 8'd0);

    // R1: reset in mid-run clears a pending response
    drive(1'b1, 8'd0, 8'd64);
    @(negedge clk);
    drive(1'b0, 8'd0, 8'd0);
    rst_n = 1'b0;
    #1;
    check_rsp("R1", 1'b0, 1'b0, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1'b1, 8'd2, 8'd0);
    @(negedge clk);
    check_rsp("R9", 1'b1, 1'b0, 8'd6);
    drive(1'b0, 8'd0, 8'd0);
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule